// File: doc/BRIEF.md
# Planar Video Memory Write Datapath

This block turns one processor byte store into the per-plane write of a planar display memory. It applies the graphics-controller rules: the selected write mode, the data rotation, the set/reset substitution, the bit mask, the logical combine with the latched bytes, and the plane enable mask. The result is one registered write beat. That beat carries a byte enable and a data byte for each of up to eight planes, plus the base address. The target of plane i is the base address with i ORed into its low bits. The memory array and the read path that fills the latch sit beside this block and are not part of it.

An extension control byte widens the datapath. It can make eight planes active instead of four, let all eight map-mask bits through, and widen the write-mode field to three bits. Widened codes 4 to 7 belong to vendor-specific write paths, so this block writes no plane for them and raises a flag.

Byte and bit convention used throughout: plane i uses byte i of the 64-bit latch and data buses (bits 8i+7 down to 8i). It also uses bit i of the set/reset, set/reset-enable and map-mask bytes.

Top module: `vga_plane_writer`

## Requirements
- R1: A write request sampled on a rising edge produces `out_valid` high on the next edge, with `plane_addr` equal to the request address. A cycle without a request gives `out_valid` low and `plane_we` all zero.
- R2: The write mode is `mode_sel[1:0]`, or `mode_sel[2:0]` when `ext_mode[2]` is 1. With `ext_mode[2]` 0, `mode_sel[2]` has no effect.
- R3: In modes 0 and 3 the input byte is rotated right by `rot_func[2:0]` places. In the other modes the rotation field has no effect.
- R4: In mode 0 a plane whose `sr_enable` bit is 1 takes 0xFF or 0x00 from its `set_reset` bit. Every other plane takes the rotated byte.
- R5: In mode 1 each enabled plane receives its own latch byte unchanged, whatever the bit mask and the logical operation.
- R6: In mode 2, bit i of the input byte becomes 0xFF or 0x00 for plane i.
- R7: In mode 3 the plane values come from the `set_reset` bits, and the bit mask for that write alone is `bit_mask` AND the rotated byte. The next write uses `bit_mask` unchanged.
- R8: `rot_func[4:3]` selects the combine with latch byte L under mask M. 00: (v&M)|(L&~M). 01: (v|~M)&L. 10: (v&M)|L. 11: (v&M)^L.
- R9: A plane is enabled only when its `map_mask` bit is 1. Only `map_mask[3:0]` counts unless `ext_mode[1]` is 1, in which case all eight bits count.
- R10: Planes 4 to 7 are never enabled unless `ext_mode[3]` is 1.
- R11: Widened write modes 4 to 7 enable no plane and set `vendor_mode` high for that beat.
- R12: While `rst` is high, and on the first cycle after it, `out_valid`, `plane_we` and `vendor_mode` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request this cycle |
| wr_addr | input | ADDR_W | Plane-group address of the write |
| wr_data | input | 8 | Processor data byte |
| set_reset | input | 8 | Set/reset value per plane |
| sr_enable | input | 8 | Set/reset enable per plane |
| rot_func | input | 8 | [2:0] rotate count, [4:3] logical operation |
| mode_sel | input | 8 | [2:0] write mode field |
| bit_mask | input | 8 | Bit mask |
| map_mask | input | 8 | Plane write enables |
| ext_mode | input | 8 | [1] all eight mask bits, [2] 3-bit mode field, [3] eight planes |
| latch_in | input | 64 | Latched bytes, plane i in byte i |
| out_valid | output | 1 | Write beat valid |
| plane_addr | output | ADDR_W | Base address of the beat |
| plane_we | output | 8 | Byte enable per plane |
| plane_data | output | 64 | Data per plane, plane i in byte i |
| vendor_mode | output | 1 | Beat carried a vendor write mode |

## Verification
The hardest case to reach is mode 3. There the effective mask depends on both the bit mask and the rotated data, so a wrong rotation or a mask that stays altered looks right unless the two are chosen to disagree. The stimulus uses a rotation that moves set bits across the mask boundary. It then follows at once with a mode 0 write under the original mask, which shows whether the reduced mask leaked into the next beat. The eight-plane paths are reached by combining each extension bit with full map masks, so that each gate on the upper planes is exercised on its own.

// File: rtl/vgaw_pkg.sv
package vgaw_pkg;

    localparam int LANES   = 8;
    localparam int BYTE_W  = 8;
    localparam int BUS_W   = LANES * BYTE_W;
    localparam int BASE_LN = 4;

    typedef enum logic [1:0] {
        WM_SUBST  = 2'd0,
        WM_COPY   = 2'd1,
        WM_SPREAD = 2'd2,
        WM_MASKED = 2'd3
    } wmode_t;

    typedef enum logic [1:0] {
        OP_SET = 2'd0,
        OP_AND = 2'd1,
        OP_OR  = 2'd2,
        OP_XOR = 2'd3
    } alu_op_t;

    typedef logic [LANES-1:0][BYTE_W-1:0] lanes_t;

    typedef struct packed {
        wmode_t           mode;
        logic             vendor;
        alu_op_t          op;
        logic [2:0]       rot;
        logic [LANES-1:0] lane_mask;
    } wctl_t;

    function automatic logic [BYTE_W-1:0] rotr8(input logic [BYTE_W-1:0] b,
                                                input logic [2:0] n);
        logic [2*BYTE_W-1:0] t;
        t = {b, b} >> n;
        return t[BYTE_W-1:0];
    endfunction

    function automatic logic [BUS_W-1:0] lane_bytes(input logic [LANES-1:0] we);
        logic [BUS_W-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*BYTE_W +: BYTE_W] = {BYTE_W{we[i]}};
        return r;
    endfunction

endpackage

// File: rtl/vgaw_ctl_decode.sv
module vgaw_ctl_decode
    import vgaw_pkg::*;
(
    input  logic [7:0] rot_func,
    input  logic [7:0] mode_sel,
    input  logic [7:0] map_mask,
    input  logic [7:0] ext_mode,
    output wctl_t      ctl
);
    localparam logic [LANES-1:0] LOW_LANES = LANES'((1 << BASE_LN) - 1);

    logic [LANES-1:0] mask_gate;
    logic [LANES-1:0] plane_gate;
    logic             wide_field;

    always_comb begin
        wide_field = ext_mode[2];
        mask_gate  = ext_mode[1] ? '1 : LOW_LANES;
        plane_gate = ext_mode[3] ? '1 : LOW_LANES;
        ctl.mode   = wmode_t'(mode_sel[1:0]);
        ctl.vendor = wide_field & mode_sel[2];
        ctl.op     = alu_op_t'(rot_func[4:3]);
        ctl.rot    = rot_func[2:0];
        ctl.lane_mask = ctl.vendor ? '0 : (map_mask & mask_gate & plane_gate);
    end

endmodule

// File: rtl/vgaw_source.sv
module vgaw_source
    import vgaw_pkg::*;
(
    input  wctl_t              ctl,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic [LANES-1:0]   set_reset,
    input  logic [LANES-1:0]   sr_enable,
    input  logic [BYTE_W-1:0]  bit_mask,
    input  lanes_t             latch,
    output lanes_t             src,
    output logic [BYTE_W-1:0]  eff_mask,
    output logic               bypass
);
    logic [BYTE_W-1:0] rotated;

    always_comb begin
        rotated  = rotr8(wr_data, ctl.rot);
        eff_mask = (ctl.mode == WM_MASKED) ? (bit_mask & rotated) : bit_mask;
        bypass   = (ctl.mode == WM_COPY);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            unique case (ctl.mode)
                WM_SUBST:  src[g] = sr_enable[g] ? {BYTE_W{set_reset[g]}} : rotated;
                WM_COPY:   src[g] = latch[g];
                WM_SPREAD: src[g] = {BYTE_W{wr_data[g]}};
                WM_MASKED: src[g] = {BYTE_W{set_reset[g]}};
                default:   src[g] = '0;
            endcase
        end
    end

endmodule

// File: rtl/vgaw_lane_alu.sv
module vgaw_lane_alu
    import vgaw_pkg::*;
(
    input  lanes_t             src,
    input  lanes_t             latch,
    input  logic [BYTE_W-1:0]  mask,
    input  alu_op_t            op,
    input  logic               bypass,
    output lanes_t             res
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] comb_v;
        always_comb begin
            unique case (op)
                OP_SET:  comb_v = (src[g] & mask) | (latch[g] & ~mask);
                OP_AND:  comb_v = (src[g] | ~mask) & latch[g];
                OP_OR:   comb_v = (src[g] & mask) | latch[g];
                OP_XOR:  comb_v = (src[g] & mask) ^ latch[g];
                default: comb_v = src[g];
            endcase
            res[g] = bypass ? src[g] : comb_v;
        end
    end

endmodule

// File: rtl/vga_plane_writer.sv
module vga_plane_writer
    import vgaw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        set_reset,
    input  logic [7:0]        sr_enable,
    input  logic [7:0]        rot_func,
    input  logic [7:0]        mode_sel,
    input  logic [7:0]        bit_mask,
    input  logic [7:0]        map_mask,
    input  logic [7:0]        ext_mode,
    input  logic [63:0]       latch_in,
    output logic              out_valid,
    output logic [ADDR_W-1:0] plane_addr,
    output logic [7:0]        plane_we,
    output logic [63:0]       plane_data,
    output logic              vendor_mode
);
    wctl_t             ctl;
    lanes_t            latch_l;
    lanes_t            src;
    lanes_t            res;
    logic [BYTE_W-1:0] eff_mask;
    logic              bypass;

    lanes_t            data_q;
    logic [LANES-1:0]  we_q;

    assign latch_l = latch_in;

    vgaw_ctl_decode u_dec (
        .rot_func (rot_func),
        .mode_sel (mode_sel),
        .map_mask (map_mask),
        .ext_mode (ext_mode),
        .ctl      (ctl)
    );

    vgaw_source u_src (
        .ctl       (ctl),
        .wr_data   (wr_data),
        .set_reset (set_reset),
        .sr_enable (sr_enable),
        .bit_mask  (bit_mask),
        .latch     (latch_l),
        .src       (src),
        .eff_mask  (eff_mask),
        .bypass    (bypass)
    );

    vgaw_lane_alu u_alu (
        .src    (src),
        .latch  (latch_l),
        .mask   (eff_mask),
        .op     (ctl.op),
        .bypass (bypass),
        .res    (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            we_q        <= '0;
            vendor_mode <= 1'b0;
            data_q      <= '0;
            plane_addr  <= '0;
        end else begin
            out_valid   <= wr_valid;
            we_q        <= wr_valid ? ctl.lane_mask : '0;
            vendor_mode <= wr_valid & ctl.vendor;
            if (wr_valid) begin
                data_q     <= res;
                plane_addr <= wr_addr;
            end
        end
    end

    assign plane_we   = we_q;
    assign plane_data = data_q;

    // R1: a request yields a beat one edge later; idle yields none
    a_r1_beat: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> out_valid);
    a_r1_idle: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> (!out_valid && plane_we == '0));

    // R9: no plane enabled outside the map mask
    a_r9_map_mask: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> ((plane_we & ~$past(map_mask)) == '0));

    // R10: upper planes stay off without the eight-plane extension
    a_r10_upper_off: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !ext_mode[3]) |=> (plane_we[7:4] == 4'h0));

    // R11: vendor modes write nothing and raise the flag
    a_r11_vendor: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && ext_mode[2] && mode_sel[2]) |=> (vendor_mode && plane_we == '0));

    // R5: copy mode forwards the latch on every enabled plane
    a_r5_copy: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && ctl.mode == WM_COPY) |=>
            (((plane_data ^ $past(latch_in)) & lane_bytes(plane_we)) == '0));

endmodule

// File: tb/tb_vga_plane_writer.sv
`timescale 1ns/1ps
module tb_vga_plane_writer;

    typedef struct packed {
        logic [7:0]  req;
        logic [7:0]  data;
        logic [7:0]  sr;
        logic [7:0]  sre;
        logic [7:0]  gr3;
        logic [7:0]  gr5;
        logic [7:0]  bm;
        logic [7:0]  mm;
        logic [7:0]  ext;
        logic [7:0]  we;
        logic        flag;
        logic [63:0] exp;
    } vec_t;

    localparam logic [63:0] LATCH = 64'h3CC31881_AA55F00F;
    localparam int NV = 18;

    // Requirement tags per row: R3 rotation, R4 set/reset, R8 combine ops,
    // R5 copy, R6 spread, R7 masked mode and mask restore, R2 field width,
    // R11 vendor, R10 plane count, R9 mask width.
    localparam vec_t VECS [NV] = '{
        '{8'd3,  8'h81, 8'h00, 8'h00, 8'h01, 8'h00, 8'hFF, 8'h0F, 8'h00, 8'h0F, 1'b0, 64'h00000000_C0C0C0C0},
        '{8'd4,  8'h12, 8'h01, 8'h05, 8'h00, 8'h00, 8'hFF, 8'h0F, 8'h00, 8'h0F, 1'b0, 64'h00000000_120012FF},
        '{8'd8,  8'h00, 8'h00, 8'h00, 8'h08, 8'h00, 8'h3C, 8'h0F, 8'h00, 8'h0F, 1'b0, 64'h00000000_8241C003},
        '{8'd8,  8'h33, 8'h00, 8'h00, 8'h10, 8'h00, 8'h0F, 8'h0F, 8'h00, 8'h0F, 1'b0, 64'h00000000_AB57F30F},
        '{8'd8,  8'hFF, 8'h00, 8'h00, 8'h18, 8'h00, 8'hFF, 8'h0F, 8'h00, 8'h0F, 1'b0, 64'h00000000_55AA0FF0},
        '{8'd8,  8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF0, 8'h0F, 8'h00, 8'h0F, 1'b0, 64'h00000000_0A05000F},
        '{8'd5,  8'h00, 8'h00, 8'h00, 8'h18, 8'h01, 8'h00, 8'h0A, 8'h00, 8'h0A, 1'b0, 64'h00000000_AA00F000},
        '{8'd6,  8'h06, 8'h00, 8'h00, 8'h03, 8'h02, 8'hFF, 8'h0F, 8'h00, 8'h0F, 1'b0, 64'h00000000_00FFFF00},
        '{8'd7,  8'h0F, 8'h03, 8'h00, 8'h02, 8'h03, 8'hF0, 8'h0F, 8'h00, 8'h0F, 1'b0, 64'h00000000_2A15F0CF},
        '{8'd7,  8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF0, 8'h0F, 8'h00, 8'h0F, 1'b0, 64'h00000000_0A05000F},
        '{8'd2,  8'h5A, 8'h00, 8'h00, 8'h00, 8'h04, 8'hFF, 8'h0F, 8'h00, 8'h0F, 1'b0, 64'h00000000_5A5A5A5A},
        '{8'd11, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h04, 8'hFF, 8'h0F, 8'h04, 8'h00, 1'b1, 64'h00000000_00000000},
        '{8'd10, 8'h99, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hF1, 8'h0E, 8'hF1, 1'b0, 64'h99999999_00000099},
        '{8'd9,  8'h99, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h08, 8'h0F, 1'b0, 64'h00000000_99999999},
        '{8'd10, 8'h99, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h02, 8'h0F, 1'b0, 64'h00000000_99999999},
        '{8'd6,  8'hA0, 8'h00, 8'h00, 8'h00, 8'h02, 8'hFF, 8'hFF, 8'h0E, 8'hFF, 1'b0, 64'hFF00FF00_00000000},
        '{8'd4,  8'h11, 8'h30, 8'hF0, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h0E, 8'hFF, 1'b0, 64'h0000FFFF_11111111},
        '{8'd11, 8'h00, 8'h00, 8'h00, 8'h00, 8'h07, 8'hFF, 8'hFF, 8'h0E, 8'h00, 1'b1, 64'h00000000_00000000}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_valid;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data, set_reset, sr_enable, rot_func, mode_sel, bit_mask, map_mask, ext_mode;
    logic [63:0] latch_in;
    logic        out_valid;
    logic [15:0] plane_addr;
    logic [7:0]  plane_we;
    logic [63:0] plane_data;
    logic        vendor_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vga_plane_writer #(.ADDR_W(16)) dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .set_reset(set_reset), .sr_enable(sr_enable),
        .rot_func(rot_func), .mode_sel(mode_sel), .bit_mask(bit_mask),
        .map_mask(map_mask), .ext_mode(ext_mode), .latch_in(latch_in),
        .out_valid(out_valid), .plane_addr(plane_addr), .plane_we(plane_we),
        .plane_data(plane_data), .vendor_mode(vendor_mode)
    );

    function automatic logic [63:0] bytes_of(input logic [7:0] we);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[i*8 +: 8] = {8{we[i]}};
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic [15:0] a);
        wr_valid  = 1'b1;
        wr_addr   = a;
        wr_data   = v.data;
        set_reset = v.sr;
        sr_enable = v.sre;
        rot_func  = v.gr3;
        mode_sel  = v.gr5;
        bit_mask  = v.bm;
        map_mask  = v.mm;
        ext_mode  = v.ext;
        latch_in  = LATCH;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        wr_valid = 1'b0; wr_addr = '0; wr_data = '0; set_reset = '0; sr_enable = '0;
        rot_func = '0; mode_sel = '0; bit_mask = 8'hFF; map_mask = '0; ext_mode = '0;
        latch_in = LATCH;
        repeat (3) @(negedge clk);
        // R12: reset state while held
        check("R12 valid", {63'b0, out_valid}, 64'd0);
        check("R12 we", {56'b0, plane_we}, 64'd0);
        check("R12 flag", {63'b0, vendor_mode}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R12 after release", {55'b0, out_valid, plane_we}, 64'd0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            string tag;
            drive(VECS[k], 16'h0100 + 16'(k));
            @(negedge clk);
            tag = $sformatf("R%0d", VECS[k].req);
            check({tag, " we"}, {56'b0, plane_we}, {56'b0, VECS[k].we});
            check({tag, " data"}, plane_data & bytes_of(plane_we),
                  VECS[k].exp & bytes_of(VECS[k].we));
            check({tag, " vendor flag R11"}, {63'b0, vendor_mode}, {63'b0, VECS[k].flag});
            check("R1 addr", {48'b0, plane_addr}, {48'b0, 16'h0100 + 16'(k)});
            check("R1 valid", {63'b0, out_valid}, 64'd1);
        end

        // R1: idle cycle gives no beat
        wr_valid = 1'b0;
        map_mask = 8'hFF;
        @(negedge clk);
        check("R1 idle valid", {63'b0, out_valid}, 64'd0);
        check("R1 idle we", {56'b0, plane_we}, 64'd0);

        // R5 with AND op and zero mask: still pure latch on all 8 planes
        drive('{8'd5, 8'hFF, 8'hFF, 8'hFF, 8'h0F, 8'h05, 8'h00, 8'hFF, 8'h0A, 8'hFF, 1'b0, LATCH},
              16'h0BEE);
        @(negedge clk);
        check("R5 wide copy data", plane_data, LATCH);
        check("R5 wide copy we", {56'b0, plane_we}, 64'h0000_0000_0000_00FF);

        // R12: reset during a request clears outputs
        drive('{8'd12, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h0F, 8'h00, 8'h0F, 1'b0, 64'd0},
              16'h0001);
        rst = 1'b1;
        @(negedge clk);
        check("R12 reset mid", {55'b0, out_valid, plane_we}, 64'd0);
        rst = 1'b0;
        wr_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule